// File: doc/BRIEF.md
# Hit Timestamp Digitizer (coarse counter pair with fine delay-line code)

This block is the digital half of a hit time-to-digital converter. A delay line locked over one reference clock period is snapshotted by the front end when a hit arrives. The block turns that 32-tap snapshot into a 5-bit fine code. It also keeps a 9-bit coarse count of reference periods and joins the two into one 14-bit timestamp. With a 50 MHz reference this gives 20 ns coarse steps and 625 ps fine bins.

The coarse count is kept twice. One copy advances on the rising clock edge and the other on the falling edge. The hit latches both copies together with the level of the reference clock at that instant. A high level means the rising-edge copy may be changing, so the falling-edge copy is used. A low level means the falling-edge copy may be changing, so the rising-edge copy is used. Either way, the count taken is one that held still for half a period before the hit.

The hit edge is asynchronous to the reference clock. The captured data crosses into the clock domain through a toggle synchronizer. It then waits in an output register until it is acknowledged. A hit that arrives while that register is occupied is dropped and recorded in a sticky flag.

Top module: `tdc_stamp_core`

## Requirements
- R1: The coarse field counts rising reference edges since the last rising edge at which reset was sampled high. It is 0 in the period that follows that edge, and it wraps from 511 to 0 without any flag.
- R2: The falling-edge counter advances half a period after the rising-edge counter. At every rising edge it leads the rising-edge counter by exactly one. As a result, hits in the high half and in the low half of the same period report the same coarse value.
- R3: A hit with the reference clock sampled high takes its coarse value from the falling-edge counter. A hit with the clock sampled low takes it from the rising-edge counter. A hit 1 ps after either clock edge, or 1 ps before one, reports the period in which it really arrived.
- R4: The fine code is the index of the lowest tap that reads 0, which is the length of the run of ones that starts at tap 0. It covers 0 to 31, and an all-zero snapshot gives 0.
- R5: A snapshot with a 1 above a 0 (a bubble), or with all 32 taps at 1, sets the error flag and forces the fine code to 31. The coarse field is still valid.
- R6: The timestamp word is coarse in bits 13:5 and fine in bits 4:0, so its value is coarse*32 + fine.
- R7: The hold flag rises no more than 4 rising edges after the hit edge, and the timestamp and error flag are valid while it is high. Hits must be at least 4 reference periods apart.
- R8: While hold is high the timestamp stays unchanged. An acknowledge sampled with hold high clears hold at that edge.
- R9: A hit that arrives while hold is high does not change the timestamp or the error flag. It sets the overflow flag, which stays set until reset.
- R10: A synchronous reset clears both counters, the timestamp, and the error, hold and overflow flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock; its level is also sampled by the hit |
| rst | input | 1 | Synchronous reset, active high (it also clears the hit-side capture) |
| hit_in | input | 1 | Asynchronous hit; its rising edge marks the event |
| taps_i | input | 32 | Delay-line snapshot; must be stable at the hit edge |
| rd_ack | input | 1 | Acknowledge that frees the output register |
| stamp_o | output | 14 | Timestamp {coarse[8:0], fine[4:0]} |
| err_o | output | 1 | Snapshot was not a clean thermometer code |
| hold_o | output | 1 | A timestamp is waiting to be read |
| ovf_o | output | 1 | Sticky: at least one hit was dropped |

## Verification
The bench places hits at swept offsets within the period, including 1 ps on each side of both clock edges, over more than 512 periods so the coarse count wraps several times. Two kinds of fault would show up here. Selecting the counter on the wrong clock level gives a value that is off by one in one half-period. Getting the half-period lead wrong shifts the two halves of a period against each other. Snapshots with a bubble or with all taps high check that the error flag is raised and the fine code saturates, instead of some partial index appearing. A second hit during hold must leave the first timestamp in place and set the sticky flag; a design that overwrote the register or cleared the flag on acknowledge would fail there.

// File: rtl/tdc_stamp_pkg.sv
`timescale 1ps/1ps
package tdc_stamp_pkg;
  localparam int COARSE_BITS = 9;
  localparam int TAP_COUNT   = 32;
  localparam int FINE_BITS   = $clog2(TAP_COUNT);
  localparam int STAMP_BITS  = COARSE_BITS + FINE_BITS;

  typedef logic [COARSE_BITS-1:0] coarse_t;
  typedef logic [FINE_BITS-1:0]   fine_t;
  typedef logic [STAMP_BITS-1:0]  stamp_t;
  typedef logic [TAP_COUNT-1:0]   taps_t;

  // Pick the counter that held still during the half period around the hit.
  function automatic coarse_t pick_coarse(input logic lvl_high,
                                          input coarse_t on_rise,
                                          input coarse_t on_fall);
    return lvl_high ? on_fall : on_rise;
  endfunction

  // Coarse in the upper field, fine in the lower field.
  function automatic stamp_t join_stamp(input coarse_t c, input fine_t f);
    return {c, f};
  endfunction
endpackage

// File: rtl/tdc_coarse_pair.sv
`timescale 1ps/1ps
module tdc_coarse_pair
  import tdc_stamp_pkg::*;
(
  input  logic    clk,
  input  logic    rst,
  output coarse_t rise_cnt,
  output coarse_t fall_cnt
);
  always_ff @(posedge clk) begin
    if (rst) rise_cnt <= '0;
    else     rise_cnt <= rise_cnt + 1'b1;
  end

  always_ff @(negedge clk) begin
    if (rst) fall_cnt <= '0;
    else     fall_cnt <= fall_cnt + 1'b1;
  end
endmodule

// File: rtl/tdc_hit_latch.sv
`timescale 1ps/1ps
module tdc_hit_latch
  import tdc_stamp_pkg::*;
(
  input  logic    hit_in,
  input  logic    rst,
  input  logic    clk_lvl,
  input  taps_t   taps_i,
  input  coarse_t rise_cnt,
  input  coarse_t fall_cnt,
  output taps_t   cap_taps,
  output coarse_t cap_rise,
  output coarse_t cap_fall,
  output logic    cap_lvl,
  output logic    hit_tog
);
  always_ff @(posedge hit_in or posedge rst) begin
    if (rst) begin
      cap_taps <= '0;
      cap_rise <= '0;
      cap_fall <= '0;
      cap_lvl  <= 1'b0;
      hit_tog  <= 1'b0;
    end else begin
      cap_taps <= taps_i;
      cap_rise <= rise_cnt;
      cap_fall <= fall_cnt;
      cap_lvl  <= clk_lvl;
      hit_tog  <= ~hit_tog;
    end
  end
endmodule

// File: rtl/tdc_therm_enc.sv
`timescale 1ps/1ps
module tdc_therm_enc
  import tdc_stamp_pkg::*;
(
  input  taps_t taps,
  output fine_t fine,
  output logic  bad
);
  logic [TAP_COUNT-2:0] bubble;
  fine_t first_zero;
  logic  seen_zero;

  // A 0 followed by a 1 anywhere above it breaks the thermometer code.
  for (genvar i = 0; i < TAP_COUNT - 1; i++) begin : g_bub
    assign bubble[i] = ~taps[i] & taps[i+1];
  end

  always_comb begin
    first_zero = '1;
    seen_zero  = 1'b0;
    for (int i = 0; i < TAP_COUNT; i++) begin
      if (!seen_zero && !taps[i]) begin
        first_zero = FINE_BITS'(i);
        seen_zero  = 1'b1;
      end
    end
  end

  assign bad  = (|bubble) | (&taps);
  assign fine = bad ? '1 : first_zero;
endmodule

// File: rtl/tdc_stamp_out.sv
`timescale 1ps/1ps
module tdc_stamp_out
  import tdc_stamp_pkg::*;
(
  input  logic    clk,
  input  logic    rst,
  input  logic    hit_tog,
  input  taps_t   cap_taps,
  input  coarse_t cap_rise,
  input  coarse_t cap_fall,
  input  logic    cap_lvl,
  input  logic    rd_ack,
  output stamp_t  stamp_o,
  output logic    err_o,
  output logic    hold_o,
  output logic    ovf_o,
  output logic    load_evt,
  output logic    drop_evt,
  output logic    ack_evt
);
  logic [2:0] sync_q;
  logic       new_evt;
  fine_t      enc_fine;
  logic       enc_bad;
  coarse_t    sel_coarse;

  tdc_therm_enc u_enc (
    .taps (cap_taps),
    .fine (enc_fine),
    .bad  (enc_bad)
  );

  always_ff @(posedge clk) begin
    if (rst) sync_q <= '0;
    else     sync_q <= {sync_q[1:0], hit_tog};
  end

  assign new_evt    = sync_q[1] ^ sync_q[2];
  assign load_evt   = new_evt & ~hold_o;
  assign drop_evt   = new_evt & hold_o;
  assign ack_evt    = rd_ack & hold_o;
  assign sel_coarse = pick_coarse(cap_lvl, cap_rise, cap_fall);

  always_ff @(posedge clk) begin
    if (rst) begin
      stamp_o <= '0;
      err_o   <= 1'b0;
      hold_o  <= 1'b0;
      ovf_o   <= 1'b0;
    end else begin
      if (load_evt) begin
        stamp_o <= join_stamp(sel_coarse, enc_fine);
        err_o   <= enc_bad;
        hold_o  <= 1'b1;
      end else if (ack_evt) begin
        hold_o  <= 1'b0;
      end
      if (drop_evt) ovf_o <= 1'b1;
    end
  end
endmodule

// File: rtl/tdc_stamp_core.sv
`timescale 1ps/1ps
module tdc_stamp_core
  import tdc_stamp_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  hit_in,
  input  logic [TAP_COUNT-1:0]  taps_i,
  input  logic                  rd_ack,
  output logic [STAMP_BITS-1:0] stamp_o,
  output logic                  err_o,
  output logic                  hold_o,
  output logic                  ovf_o
);
  coarse_t cnt_rise, cnt_fall, cap_rise, cap_fall;
  taps_t   cap_taps;
  logic    cap_lvl, hit_tog;
  logic    load_evt, drop_evt, ack_evt;

  tdc_coarse_pair u_cnt (
    .clk      (clk),
    .rst      (rst),
    .rise_cnt (cnt_rise),
    .fall_cnt (cnt_fall)
  );

  tdc_hit_latch u_cap (
    .hit_in   (hit_in),
    .rst      (rst),
    .clk_lvl  (clk),
    .taps_i   (taps_i),
    .rise_cnt (cnt_rise),
    .fall_cnt (cnt_fall),
    .cap_taps (cap_taps),
    .cap_rise (cap_rise),
    .cap_fall (cap_fall),
    .cap_lvl  (cap_lvl),
    .hit_tog  (hit_tog)
  );

  tdc_stamp_out u_out (
    .clk      (clk),
    .rst      (rst),
    .hit_tog  (hit_tog),
    .cap_taps (cap_taps),
    .cap_rise (cap_rise),
    .cap_fall (cap_fall),
    .cap_lvl  (cap_lvl),
    .rd_ack   (rd_ack),
    .stamp_o  (stamp_o),
    .err_o    (err_o),
    .hold_o   (hold_o),
    .ovf_o    (ovf_o),
    .load_evt (load_evt),
    .drop_evt (drop_evt),
    .ack_evt  (ack_evt)
  );
endmodule

// File: rtl/tdc_stamp_chk.sv
`timescale 1ps/1ps
module tdc_stamp_chk
  import tdc_stamp_pkg::*;
(
  input logic    clk,
  input logic    rst,
  input coarse_t cnt_rise,
  input coarse_t cnt_fall,
  input stamp_t  stamp_o,
  input logic    err_o,
  input logic    hold_o,
  input logic    ovf_o,
  input logic    load_evt,
  input logic    drop_evt,
  input logic    ack_evt
);
  // R2
  half_lead_chk: assert property (@(posedge clk) disable iff (rst)
    cnt_fall == coarse_t'(cnt_rise + 1'b1));

  // R5
  err_sat_chk: assert property (@(posedge clk) disable iff (rst)
    err_o |-> stamp_o[FINE_BITS-1:0] == '1);

  // R7
  load_hold_chk: assert property (@(posedge clk) disable iff (rst)
    load_evt |=> hold_o);

  // R8
  hold_keep_chk: assert property (@(posedge clk) disable iff (rst)
    (hold_o && !ack_evt) |=> (hold_o && $stable(stamp_o) && $stable(err_o)));

  // R8
  ack_clear_chk: assert property (@(posedge clk) disable iff (rst)
    ack_evt |=> !hold_o);

  // R9
  drop_flag_chk: assert property (@(posedge clk) disable iff (rst)
    drop_evt |=> ovf_o);

  // R9
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    ovf_o |=> ovf_o);

  // R10
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (stamp_o == '0 && !err_o && !hold_o && !ovf_o));
endmodule

bind tdc_stamp_core tdc_stamp_chk u_chk (
  .clk      (clk),
  .rst      (rst),
  .cnt_rise (cnt_rise),
  .cnt_fall (cnt_fall),
  .stamp_o  (stamp_o),
  .err_o    (err_o),
  .hold_o   (hold_o),
  .ovf_o    (ovf_o),
  .load_evt (load_evt),
  .drop_evt (drop_evt),
  .ack_evt  (ack_evt)
);

// File: tb/sim_tdc_stamp_core.sv
`timescale 1ps/1ps
module sim_tdc_stamp_core;
  localparam int PER  = 10000;
  localparam int HALF = PER / 2;
  localparam int NBIN = 32;
  localparam int CMOD = 512;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        hit_in = 1'b0;
  logic [31:0] taps_i = '0;
  logic        rd_ack = 1'b0;
  logic [13:0] stamp_o;
  logic        err_o, hold_o, ovf_o;

  int     errs = 0;
  int     checks = 0;
  longint t_rst = 0;
  bit     done = 1'b0;

  always #HALF clk = ~clk;

  tdc_stamp_core u0 (
    .clk(clk), .rst(rst), .hit_in(hit_in), .taps_i(taps_i), .rd_ack(rd_ack),
    .stamp_o(stamp_o), .err_o(err_o), .hold_o(hold_o), .ovf_o(ovf_o)
  );

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int bin_of(input int off);
    return (off * NBIN) / PER;
  endfunction

  function automatic logic [31:0] therm(input int n);
    return (n == 0) ? 32'h0 : (32'hFFFF_FFFF >> (32 - n));
  endfunction

  task automatic do_reset();
    rst = 1'b1;
    repeat (3) @(posedge clk);
    t_rst = $time;
    #2500 rst = 1'b0;
  endtask

  task automatic fire(input int off, input logic [31:0] pat, output longint per_idx);
    @(posedge clk);
    per_idx = ($time - t_rst) / PER;
    taps_i = pat;
    #(off) hit_in = 1'b1;
    #300 hit_in = 1'b0;
  endtask

  task automatic wait_hold(output int lat);
    lat = 0;
    while (lat < 6) begin
      @(posedge clk);
      lat++;
      #2000;
      if (hold_o) break;
    end
  endtask

  task automatic ack_it(input string req);
    rd_ack = 1'b1;
    @(posedge clk);
    #2000 rd_ack = 1'b0;
    check(hold_o == 1'b0, req, hold_o, 0);
  endtask

  task automatic check_clear(input string req);
    check(stamp_o == 14'd0, req, stamp_o, 0);
    check(hold_o == 1'b0, req, hold_o, 0);
    check(err_o == 1'b0, req, err_o, 0);
    check(ovf_o == 1'b0, req, ovf_o, 0);
  endtask

  initial begin
    #(64'd2000000000);
    if (!done) begin
      errs++;
      checks++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin
    longint k, k2;
    int     lat, off, f, exc;
    logic [13:0] keep;

    do_reset();
    @(posedge clk);
    #2000 check_clear("R10 after reset");

    // Sweep hit positions over many periods; the coarse count wraps (R1).
    for (int i = 0; i < 700; i++) begin
      off = (i * 317 + 11) % PER;
      case (i % 9)
        0: off = 1;
        1: off = HALF - 1;
        2: off = HALF + 1;
        3: off = PER - 1;
        default: ;
      endcase
      if (off == 0 || off == HALF) off += 3;
      f = bin_of(off);
      fire(off, therm(f), k);
      wait_hold(lat);
      check(hold_o && lat <= 4, "R7 latency", lat, 4);
      exc = int'(k % CMOD);
      // R2 / R3: both halves of a period must report the same period index
      check(stamp_o[13:5] == exc[8:0], off < HALF ? "R2 R3 high half coarse" : "R1 R3 low half coarse",
            stamp_o[13:5], exc);
      check(stamp_o[4:0] == f[4:0], "R4 fine code", stamp_o[4:0], f);
      check(stamp_o == 14'(exc * 32 + f), "R6 word layout", stamp_o, exc * 32 + f);
      check(err_o == 1'b0, "R5 clean code", err_o, 0);
      ack_it("R8 ack clears hold");
    end

    // R5: bubbles and all-ones
    for (int j = 0; j < 4; j++) begin
      logic [31:0] pat;
      case (j)
        0: pat = 32'hFFFF_FFFF;
        1: pat = 32'h0000_00F5;
        2: pat = 32'h8000_0001;
        default: pat = 32'h0000_FF00;
      endcase
      fire(1234, pat, k);
      wait_hold(lat);
      exc = int'(k % CMOD);
      check(err_o == 1'b1, "R5 error flag", err_o, 1);
      check(stamp_o[4:0] == 5'd31, "R5 fine saturates", stamp_o[4:0], 31);
      check(stamp_o[13:5] == exc[8:0], "R5 coarse still valid", stamp_o[13:5], exc);
      ack_it("R8 ack after error");
    end

    // R9: a hit during hold is dropped
    fire(2000, therm(6), k);
    wait_hold(lat);
    exc = int'(k % CMOD);
    keep = 14'(exc * 32 + 6);
    check(stamp_o == keep && ovf_o == 1'b0, "R9 first stamp", stamp_o, keep);
    repeat (3) @(posedge clk);
    fire(7000, 32'h0000_00F5, k2);
    repeat (5) @(posedge clk);
    #2000;
    check(stamp_o == keep, "R9 stamp unchanged", stamp_o, keep);
    check(err_o == 1'b0, "R9 error unchanged", err_o, 0);
    check(hold_o == 1'b1, "R8 hold kept", hold_o, 1);
    check(ovf_o == 1'b1, "R9 overflow set", ovf_o, 1);
    ack_it("R8 ack after drop");
    check(ovf_o == 1'b1, "R9 overflow sticky over ack", ovf_o, 1);
    fire(8000, therm(25), k);
    wait_hold(lat);
    exc = int'(k % CMOD);
    check(stamp_o == 14'(exc * 32 + 25), "R9 next hit accepted", stamp_o, exc * 32 + 25);
    check(ovf_o == 1'b1, "R9 overflow still set", ovf_o, 1);

    // R10: reset while a stamp waits
    do_reset();
    @(posedge clk);
    #2000 check_clear("R10 reset clears flags");
    fire(3000, therm(9), k);
    wait_hold(lat);
    check(stamp_o == 14'(k * 32 + 9), "R10 R1 counters restart", stamp_o, k * 32 + 9);
    ack_it("R8 final ack");

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule